// File: doc/BRIEF.md
# Two-Player LED Ping-Pong Controller

This block runs a table-tennis game for two players on a strip of eight LEDs. One lit LED stands for the ball. The two middle LEDs stand for the net and are always on. Player A sits at LED 0 and player B sits at LED 7. The serving player starts a rally. The ball then travels one LED per step tick toward the other player. The receiver may strike it only while it sits on the receiver's own end LED. A strike there sends the ball back. Striking too early, or not striking at all, gives the point to the opponent.

The surrounding logic supplies debounced serve and hit levels, a run/pause level and a one-cycle step tick from a slow divider. The block drives the LED bits and two binary score counters. A game ends when a player would reach 21; both scores then clear and play continues from the serve. The reset input is active low and asserts asynchronously. Its release is synchronised inside the block, which takes two clock edges.

Top module: `pong_core`

## Requirements
- R1: While `rst_n` is low, and immediately after it falls with no clock edge needed, `led` is 8'h18 and both scores are zero. The game is then waiting for a serve.
- R2: LED bits 3 and 4 (the net) are always lit. While waiting for a serve no other bit is lit. During a rally exactly the bit at the ball position is added to the net bits, so `led` is 8'h18 OR (1 << position).
- R3: Ball position, game state and scores change only on a clock edge where `step` and `play_en` are both high.
- R4: While waiting, a step with `serve_a` alone puts the ball on bit 0, and a step with `serve_b` alone puts it on bit 7. A step with both serve inputs high leaves the game waiting.
- R5: In flight, each step moves the ball one bit toward the receiver: upward toward B at bit 7, downward toward A at bit 0.
- R6: A receiver hit seen before the ball reaches the receiver's end bit counts as early. The server's score rises by one and the game returns to waiting. This applies from the serve LED onward, and a hit that arrives between steps is kept and judged at the next step.
- R7: With the ball on the receiver's end bit, a step with a hit returns the ball one bit toward the other player.
- R8: With the ball on the receiver's end bit, a step without a hit is a miss. The other player scores and the game returns to waiting.
- R9: Hits from the player who is not receiving have no effect on the rally.
- R10: A hit is a rising edge of `hit_a` or `hit_b`. A level held high across later steps gives no further hit.
- R11: A point that would bring either score to 21 instead clears both scores to zero. No score output ever shows 21 or more.
- R12: While `play_en` is low, steps are ignored and hit edges arriving then are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| play_en | input | 1 | Run level; low pauses the game |
| serve_a | input | 1 | Serve request from player A (LED 0 end) |
| serve_b | input | 1 | Serve request from player B (LED 7 end) |
| hit_a | input | 1 | Hit level from player A, edge-detected |
| hit_b | input | 1 | Hit level from player B, edge-detected |
| step | input | 1 | One-cycle ball-advance tick |
| led | output | 8 | LED drive, bit 0 at A's end |
| score_a | output | 5 | Player A score, binary |
| score_b | output | 5 | Player B score, binary |

## Verification
A corrupted game state or ball position shows on `led` in the same cycle. This holds for every position except the two net bits, where the ball is hidden. A wrong position there shows within one or two steps, when the ball leaves the net. A wrong state, such as the wrong receiver or a missed return window, shows either as a ball moving the wrong way on the next step or as a score changing one step early or late. The stimulus therefore plays long rallies through both ends and checks `led` and both scores after every cycle, so any slip is caught no more than one step after it happens. A bad hit latch shows as a point awarded, or not awarded, on the step after the hit edge.

// File: rtl/pong_pkg.sv
package pong_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRV_A,
    ST_SRV_B,
    ST_TO_B,
    ST_TO_A,
    ST_WIN_A,
    ST_WIN_B
  } pong_state_e;
endpackage

// File: rtl/pong_rst_sync.sv
module pong_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pong_hit_latch.sv
module pong_hit_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_in,
  input  logic consume,
  input  logic discard,
  output logic seen
);
  logic prev_q, pend_q;
  logic rise, pend_d;

  always_comb begin
    rise = hit_in & ~prev_q;
    seen = pend_q | rise;
    if (discard || consume) pend_d = 1'b0;
    else                    pend_d = pend_q | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= hit_in;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/pong_ball_fsm.sv
module pong_ball_fsm
  import pong_pkg::*;
#(
  parameter int NUM_LEDS = 8,
  localparam int POS_W = $clog2(NUM_LEDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             serve_a,
  input  logic             serve_b,
  input  logic             seen_a,
  input  logic             seen_b,
  output pong_state_e      state,
  output logic [POS_W-1:0] pos,
  output logic             pt_a,
  output logic             pt_b
);
  localparam logic [POS_W-1:0] FIRST = '0;
  localparam logic [POS_W-1:0] LAST  = POS_W'(NUM_LEDS - 1);
  localparam logic [POS_W-1:0] ONE   = POS_W'(1);

  pong_state_e      st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    st_d  = st_q;
    pos_d = pos_q;
    pt_a  = 1'b0;
    pt_b  = 1'b0;
    if (adv) begin
      unique case (st_q)
        ST_IDLE: begin
          if (serve_a && !serve_b) begin
            st_d  = ST_SRV_A;
            pos_d = FIRST;
          end else if (serve_b && !serve_a) begin
            st_d  = ST_SRV_B;
            pos_d = LAST;
          end
        end
        ST_SRV_A, ST_TO_B: begin
          if (seen_b) begin
            pt_a  = 1'b1;
            st_d  = ST_IDLE;
            pos_d = FIRST;
          end else begin
            pos_d = pos_q + ONE;
            st_d  = ((pos_q + ONE) == LAST) ? ST_WIN_B : ST_TO_B;
          end
        end
        ST_SRV_B, ST_TO_A: begin
          if (seen_a) begin
            pt_b  = 1'b1;
            st_d  = ST_IDLE;
            pos_d = FIRST;
          end else begin
            pos_d = pos_q - ONE;
            st_d  = ((pos_q - ONE) == FIRST) ? ST_WIN_A : ST_TO_A;
          end
        end
        ST_WIN_B: begin
          if (seen_b) begin
            st_d  = ST_TO_A;
            pos_d = LAST - ONE;
          end else begin
            pt_a  = 1'b1;
            st_d  = ST_IDLE;
            pos_d = FIRST;
          end
        end
        ST_WIN_A: begin
          if (seen_a) begin
            st_d  = ST_TO_B;
            pos_d = FIRST + ONE;
          end else begin
            pt_b  = 1'b1;
            st_d  = ST_IDLE;
            pos_d = FIRST;
          end
        end
        default: begin
          st_d  = ST_IDLE;
          pos_d = FIRST;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pos_q <= FIRST;
    end else begin
      st_q  <= st_d;
      pos_q <= pos_d;
    end
  end

  assign state = st_q;
  assign pos   = pos_q;
endmodule

// File: rtl/pong_score.sv
module pong_score #(
  parameter int WIN_SCORE = 21,
  localparam int SCORE_W = $clog2(WIN_SCORE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pt_a,
  input  logic               pt_b,
  output logic [SCORE_W-1:0] score_a,
  output logic [SCORE_W-1:0] score_b
);
  localparam logic [SCORE_W-1:0] WIN = SCORE_W'(WIN_SCORE);
  localparam logic [SCORE_W-1:0] ONE = SCORE_W'(1);

  logic [SCORE_W-1:0] a_q, b_q, a_d, b_d, a_inc, b_inc;

  always_comb begin
    a_inc = a_q + ONE;
    b_inc = b_q + ONE;
    a_d   = a_q;
    b_d   = b_q;
    if ((pt_a && a_inc == WIN) || (pt_b && b_inc == WIN)) begin
      a_d = '0;
      b_d = '0;
    end else if (pt_a) begin
      a_d = a_inc;
    end else if (pt_b) begin
      b_d = b_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (pt_a || pt_b) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign score_a = a_q;
  assign score_b = b_q;
endmodule

// File: rtl/pong_core.sv
module pong_core
  import pong_pkg::*;
#(
  parameter int NUM_LEDS  = 8,
  parameter int WIN_SCORE = 21,
  localparam int SCORE_W  = $clog2(WIN_SCORE + 1),
  localparam int POS_W    = $clog2(NUM_LEDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                play_en,
  input  logic                serve_a,
  input  logic                serve_b,
  input  logic                hit_a,
  input  logic                hit_b,
  input  logic                step,
  output logic [NUM_LEDS-1:0] led,
  output logic [SCORE_W-1:0]  score_a,
  output logic [SCORE_W-1:0]  score_b
);
  localparam int NET_LO = NUM_LEDS / 2 - 1;
  localparam int NET_HI = NUM_LEDS / 2;

  logic             rst_sync_n;
  logic             adv;
  logic [1:0]       hit_lvl, hit_seen;
  pong_state_e      fsm_st;
  logic [POS_W-1:0] ball_pos;
  logic             pt_a, pt_b;
  logic             in_play;

  assign adv     = step & play_en;
  assign hit_lvl = {hit_b, hit_a};

  pong_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  for (genvar p = 0; p < 2; p++) begin : g_hit
    pong_hit_latch u_hit (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .hit_in  (hit_lvl[p]),
      .consume (adv),
      .discard (~play_en),
      .seen    (hit_seen[p])
    );
  end

  pong_ball_fsm #(.NUM_LEDS(NUM_LEDS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv     (adv),
    .serve_a (serve_a),
    .serve_b (serve_b),
    .seen_a  (hit_seen[0]),
    .seen_b  (hit_seen[1]),
    .state   (fsm_st),
    .pos     (ball_pos),
    .pt_a    (pt_a),
    .pt_b    (pt_b)
  );

  pong_score #(.WIN_SCORE(WIN_SCORE)) u_score (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pt_a    (pt_a),
    .pt_b    (pt_b),
    .score_a (score_a),
    .score_b (score_b)
  );

  assign in_play = (fsm_st != ST_IDLE);

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    if (i == NET_LO || i == NET_HI) begin : g_net
      assign led[i] = 1'b1;
    end else begin : g_table
      assign led[i] = in_play && (ball_pos == POS_W'(i));
    end
  end
endmodule

// File: rtl/pong_core_chk.sv
module pong_core_chk
  import pong_pkg::*;
#(
  parameter int NUM_LEDS  = 8,
  parameter int WIN_SCORE = 21,
  localparam int SCORE_W  = $clog2(WIN_SCORE + 1),
  localparam int POS_W    = $clog2(NUM_LEDS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                play_en,
  input logic                serve_a,
  input logic                serve_b,
  input logic                step,
  input logic [NUM_LEDS-1:0] led,
  input logic [SCORE_W-1:0]  score_a,
  input logic [SCORE_W-1:0]  score_b,
  input pong_state_e         st,
  input logic [POS_W-1:0]    pos
);
  localparam int NET_LO = NUM_LEDS / 2 - 1;
  localparam int NET_HI = NUM_LEDS / 2;

  p_net_lit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    led[NET_LO] && led[NET_HI] && ($countones(led) <= 3));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && play_en) |=> $stable(led) && $stable(score_a) && $stable(score_b));

  p_serve_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && step && play_en && serve_a && !serve_b) |=> led[0] && (st == ST_SRV_A));

  p_both_serve_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && step && play_en && serve_a && serve_b) |=> (st == ST_IDLE));

  p_move_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TO_B && step && play_en) |=>
      (st == ST_IDLE) || (pos == $past(pos) + POS_W'(1)));

  p_score_inc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (score_a != $past(score_a)) |->
      (score_a == $past(score_a) + SCORE_W'(1)) || (score_a == '0 && score_b == '0));

  p_below_win_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (score_a < SCORE_W'(WIN_SCORE)) && (score_b < SCORE_W'(WIN_SCORE)));
endmodule

bind pong_core pong_core_chk #(.NUM_LEDS(NUM_LEDS), .WIN_SCORE(WIN_SCORE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .play_en (play_en),
  .serve_a (serve_a),
  .serve_b (serve_b),
  .step    (step),
  .led     (led),
  .score_a (score_a),
  .score_b (score_b),
  .st      (fsm_st),
  .pos     (ball_pos)
);

// File: tb/test_pong_core.sv
`timescale 1ns/1ps
module test_pong_core;
  logic       clk = 1'b0;
  logic       rst_n, play_en, serve_a, serve_b, hit_a, hit_b, step;
  logic [7:0] led;
  logic [4:0] score_a, score_b;
  int         n_vec = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  pong_core i_pong_core (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .serve_a(serve_a),
    .serve_b(serve_b), .hit_a(hit_a), .hit_b(hit_b), .step(step),
    .led(led), .score_a(score_a), .score_b(score_b)
  );

  // {en,sa,sb,ha,hb,step} led score_a score_b req
  localparam int NV = 52;
  localparam logic [27:0] VECS [0:NV-1] = '{
    {6'b100000, 8'h18, 5'd0, 5'd0, 4'd2},  // R2 idle shows net only
    {6'b111001, 8'h18, 5'd0, 5'd0, 4'd4},  // R4 both serve ignored
    {6'b110001, 8'h19, 5'd0, 5'd0, 4'd4},  // R4 A serves at bit 0
    {6'b100001, 8'h1A, 5'd0, 5'd0, 4'd5},  // R5
    {6'b100000, 8'h1A, 5'd0, 5'd0, 4'd3},  // R3 no step, hold
    {6'b100101, 8'h1C, 5'd0, 5'd0, 4'd9},  // R9 server hit ignored
    {6'b100001, 8'h18, 5'd0, 5'd0, 4'd5},
    {6'b100001, 8'h18, 5'd0, 5'd0, 4'd5},
    {6'b100001, 8'h38, 5'd0, 5'd0, 4'd5},
    {6'b100001, 8'h58, 5'd0, 5'd0, 4'd5},
    {6'b100001, 8'h98, 5'd0, 5'd0, 4'd5},  // B end bit
    {6'b100011, 8'h58, 5'd0, 5'd0, 4'd7},  // R7 B returns
    {6'b100011, 8'h38, 5'd0, 5'd0, 4'd5},
    {6'b100001, 8'h18, 5'd0, 5'd0, 4'd5},
    {6'b100001, 8'h18, 5'd0, 5'd0, 4'd5},
    {6'b100001, 8'h1C, 5'd0, 5'd0, 4'd5},
    {6'b100001, 8'h1A, 5'd0, 5'd0, 4'd5},
    {6'b100001, 8'h19, 5'd0, 5'd0, 4'd5},
    {6'b100000, 8'h19, 5'd0, 5'd0, 4'd3},
    {6'b100001, 8'h18, 5'd0, 5'd1, 4'd8},  // R8 A misses
    {6'b101001, 8'h98, 5'd0, 5'd1, 4'd4},  // R4 B serves at bit 7
    {6'b100001, 8'h58, 5'd0, 5'd1, 4'd5},
    {6'b100100, 8'h58, 5'd0, 5'd1, 4'd3},  // hit between steps kept
    {6'b100001, 8'h18, 5'd0, 5'd2, 4'd6},  // R6 A early
    {6'b110001, 8'h19, 5'd0, 5'd2, 4'd4},
    {6'b100011, 8'h18, 5'd1, 5'd2, 4'd6},  // R6 B early on serve LED
    {6'b001001, 8'h18, 5'd1, 5'd2, 4'd12}, // R12 paused serve
    {6'b101001, 8'h98, 5'd1, 5'd2, 4'd4},
    {6'b000101, 8'h98, 5'd1, 5'd2, 4'd12}, // R12 paused step and hit
    {6'b100001, 8'h58, 5'd1, 5'd2, 4'd12}, // paused hit discarded
    {6'b100001, 8'h38, 5'd1, 5'd2, 4'd5},
    {6'b100001, 8'h18, 5'd1, 5'd2, 4'd5},
    {6'b100001, 8'h18, 5'd1, 5'd2, 4'd5},
    {6'b100001, 8'h1C, 5'd1, 5'd2, 4'd5},
    {6'b100001, 8'h1A, 5'd1, 5'd2, 4'd5},
    {6'b100001, 8'h19, 5'd1, 5'd2, 4'd5},
    {6'b100101, 8'h1A, 5'd1, 5'd2, 4'd7},  // R7 A returns, then holds
    {6'b100101, 8'h1C, 5'd1, 5'd2, 4'd9},
    {6'b100101, 8'h18, 5'd1, 5'd2, 4'd5},
    {6'b100101, 8'h18, 5'd1, 5'd2, 4'd5},
    {6'b100101, 8'h38, 5'd1, 5'd2, 4'd5},
    {6'b100101, 8'h58, 5'd1, 5'd2, 4'd5},
    {6'b100101, 8'h98, 5'd1, 5'd2, 4'd5},
    {6'b100111, 8'h58, 5'd1, 5'd2, 4'd7},
    {6'b100101, 8'h38, 5'd1, 5'd2, 4'd10}, // held A level no early hit
    {6'b100101, 8'h18, 5'd1, 5'd2, 4'd10},
    {6'b100101, 8'h18, 5'd1, 5'd2, 4'd10},
    {6'b100101, 8'h1C, 5'd1, 5'd2, 4'd10},
    {6'b100101, 8'h1A, 5'd1, 5'd2, 4'd10},
    {6'b100101, 8'h19, 5'd1, 5'd2, 4'd10},
    {6'b100101, 8'h18, 5'd1, 5'd3, 4'd10}, // R10 held level is a miss
    {6'b100000, 8'h18, 5'd1, 5'd3, 4'd3}
  };

  task automatic cyc(input logic [5:0] c);
    {play_en, serve_a, serve_b, hit_a, hit_b, step} = c;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input int req, input logic [7:0] el, input logic [4:0] ea, input logic [4:0] eb);
    n_vec++;
    if (led !== el || score_a !== ea || score_b !== eb) begin
      n_bad++;
      $display("FAIL R%0d led=%h exp %h score_a=%0d exp %0d score_b=%0d exp %0d",
               req, led, el, score_a, ea, score_b, eb);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL R0 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {play_en, serve_a, serve_b, hit_a, hit_b, step} = 6'b0;
    #12;
    chk(1, 8'h18, 5'd0, 5'd0);  // R1 reset state
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) cyc(6'b100000);
    chk(1, 8'h18, 5'd0, 5'd0);  // R1 after release

    for (int k = 0; k < NV; k++) begin
      cyc(VECS[k][27:22]);
      chk(int'(VECS[k][3:0]), VECS[k][21:14], VECS[k][13:9], VECS[k][8:4]);
    end

    // R1: asynchronous reset in mid-rally
    cyc(6'b110001);
    chk(4, 8'h19, 5'd1, 5'd3);
    #1 rst_n = 1'b0;
    #0.5;
    chk(1, 8'h18, 5'd0, 5'd0);
    cyc(6'b100000);
    rst_n = 1'b1;
    repeat (3) cyc(6'b100000);
    chk(1, 8'h18, 5'd0, 5'd0);

    // R11: B takes one point, then A reaches game point
    cyc(6'b101001);
    chk(4, 8'h98, 5'd0, 5'd0);
    cyc(6'b100101);
    chk(6, 8'h18, 5'd0, 5'd1);
    for (int k = 1; k <= 21; k++) begin
      cyc(6'b110001);
      chk(4, 8'h19, 5'(k - 1), 5'd1);
      cyc(6'b100011);
      if (k < 21) chk(6, 8'h18, 5'(k), 5'd1);
      else        chk(11, 8'h18, 5'd0, 5'd0);  // R11 both clear
    end
    cyc(6'b100000);
    chk(11, 8'h18, 5'd0, 5'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule